// File: doc/BRIEF.md
# Privilege Mode and Status CSR Unit

This block keeps a hart's current privilege mode and the machine status word that goes with it. The mode is held in an internal register that no CSR address returns. It is visible only on a port for the rest of the pipeline. The supervisor status register has no storage of its own. It is a masked window onto the machine status word, so supervisor software can change its own enable and previous-mode fields without entering machine mode.

Every CSR access is checked against the current mode. The minimum level is taken from address bits [9:8]. A write to a read-only address is refused. A refused access returns zero and changes nothing. Three strobes (trap entry, machine return, supervisor return) apply the state updates for entering and leaving traps. Two configuration inputs say whether user mode and supervisor mode exist. Every mode value that is requested, from a return or from a write of the machine previous-mode field, is legalized against them.

The mode register is a three-state machine with states MODE_U, MODE_S and MODE_M. MODE_RSV is unreachable, and if it ever held it would fall back to MODE_M. Each cycle one event is chosen by priority. EV_TRAP moves the machine to MODE_M. EV_MRET moves it to the legalized machine previous mode. EV_SRET moves it to the legalized supervisor previous mode. EV_NONE keeps the current state.

Top module: `priv_status_unit`

## Requirements
- R1: After reset the mode is M (2'b11). The machine status word reads 0x0000_1800: the machine previous-mode field is M and every enable and previous-enable bit is 0. The layout is SIE bit 1, MIE bit 3, SPIE bit 5, MPIE bit 7, SPP bit 8, MPP bits [12:11]. Modes are encoded U=2'b00, S=2'b01, M=2'b11.
- R2: A requested mode is legalized as follows. With user mode unsupported, it becomes M. If the request is 2'b10, or is S with supervisor mode unsupported, it becomes U. Any other request is kept. This rule applies to writes of MPP and to the target of both returns, and the mode output never shows 2'b10.
- R3: An access with csr_req high is flagged illegal when the current mode is below the level in address bits [9:8]. The value 2'b10 in those bits counts as S.
- R4: A write (csr_we high) to an address whose bits [11:10] are 2'b11 is flagged illegal even when privilege is sufficient.
- R5: An illegal access returns zero read data and leaves the status word unchanged.
- R6: The machine status word is at 0x300 and the supervisor view is at 0x100. The supervisor view reads the status word masked to SIE, SPIE and SPP. A write to it changes only those three bits.
- R7: On a machine return: MIE takes MPIE, the mode becomes the legalized MPP, MPIE becomes 1, and MPP becomes U (or M when user mode is unsupported).
- R8: On a supervisor return: SIE takes SPIE, the mode becomes the legalized value of SPP (1 means S, 0 means U), SPIE becomes 1, and SPP becomes 0.
- R9: On trap entry: MPIE takes MIE, MIE is cleared, MPP takes the current mode, and the mode becomes M.
- R10: When several events occur in one cycle, trap entry wins over machine return, which wins over supervisor return, which wins over a CSR write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_umode | input | 1 | User mode is supported |
| en_smode | input | 1 | Supervisor mode is supported |
| csr_req | input | 1 | CSR access present this cycle |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data, zero when illegal or unmapped |
| csr_illegal | output | 1 | Access refused (illegal instruction) |
| trap_take | input | 1 | Trap entry into machine mode |
| mret_take | input | 1 | Machine return |
| sret_take | input | 1 | Supervisor return |
| cur_mode | output | 2 | Current privilege mode |

## Verification
The bench sweeps all four support configurations. In each one it writes each of the four MPP values and performs a machine return. The resulting mode separates the legalization cases: reserved value, missing supervisor mode and missing user mode. In every mode reached this way, all sixteen values of address bits [11:8] are tried as both read and write. This separates the privilege comparison, the hypervisor-class remap and the read-only rule. Supervisor-view writes of all zeros and all ones, taken after a full machine-status write, show that the machine-only bits survive. A supervisor return, followed by accesses from the resulting mode and a trap back, shows which writes took effect. Simultaneous strobes show the priority order.

// File: rtl/priv_pkg.sv
package priv_pkg;

    typedef enum logic [1:0] {
        MODE_U   = 2'b00,
        MODE_S   = 2'b01,
        MODE_RSV = 2'b10,
        MODE_M   = 2'b11
    } pmode_e;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_TRAP,
        EV_MRET,
        EV_SRET
    } pevent_e;

    // Status word bit positions
    localparam int B_SIE    = 1;
    localparam int B_MIE    = 3;
    localparam int B_SPIE   = 5;
    localparam int B_MPIE   = 7;
    localparam int B_SPP    = 8;
    localparam int B_MPP_LO = 11;
    localparam int B_MPP_HI = 12;

    // Fold a requested mode onto one the configuration supports
    function automatic logic [1:0] legalize_mode(input logic [1:0] req,
                                                 input logic       u_ok,
                                                 input logic       s_ok);
        logic [1:0] res;
        if (!u_ok)
            res = MODE_M;
        else if (req == MODE_RSV || (req == MODE_S && !s_ok))
            res = MODE_U;
        else
            res = req;
        return res;
    endfunction

endpackage

// File: rtl/priv_csr_gate.sv
module priv_csr_gate
    import priv_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  pmode_e        mode,
    output logic          illegal,
    output logic          wr_ok,
    output logic          rd_ok
);
    localparam int LVL_LO = 8;
    localparam int RO_LO  = 10;

    logic [1:0] need_lvl;
    logic       low_priv;
    logic       ro_write;
    logic       unused_abits;

    assign unused_abits = ^addr[LVL_LO-1:0];

    always_comb begin
        // hypervisor-class addresses count as supervisor level
        need_lvl = (addr[LVL_LO+1:LVL_LO] == 2'b10) ? 2'b01 : addr[LVL_LO+1:LVL_LO];
        low_priv = (mode < need_lvl);
        ro_write = we && (addr[RO_LO+1:RO_LO] == 2'b11);
        illegal  = req && (low_priv || ro_write);
        wr_ok    = req && we && !illegal;
        rd_ok    = req && !illegal;
    end

    a_r4_ro_write_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we && addr[RO_LO+1:RO_LO] == 2'b11) |-> (illegal && !wr_ok));

    a_r3_machine_level: assert property (@(posedge clk) disable iff (!rst_n)
        (req && addr[LVL_LO+1:LVL_LO] == 2'b11 && mode != MODE_M) |-> (illegal && !rd_ok));

endmodule

// File: rtl/priv_mode_fsm.sv
module priv_mode_fsm
    import priv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       u_ok,
    input  logic       s_ok,
    input  logic       trap,
    input  logic       mret,
    input  logic       sret,
    input  logic [1:0] mpp,
    input  logic       spp,
    output pmode_e     mode_q
);
    pevent_e ev;
    pmode_e  mode_d;

    always_comb begin
        if (trap)      ev = EV_TRAP;
        else if (mret) ev = EV_MRET;
        else if (sret) ev = EV_SRET;
        else           ev = EV_NONE;
    end

    always_comb begin
        mode_d = mode_q;
        unique case (ev)
            EV_TRAP: mode_d = MODE_M;
            EV_MRET: mode_d = pmode_e'(legalize_mode(mpp, u_ok, s_ok));
            EV_SRET: mode_d = pmode_e'(legalize_mode({1'b0, spp}, u_ok, s_ok));
            EV_NONE: mode_d = (mode_q == MODE_RSV) ? MODE_M : mode_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_M;
        else        mode_q <= mode_d;
    end

    a_r9_trap_enters_m: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> (mode_q == MODE_M));

    a_r2_no_reserved_mode: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q != MODE_RSV);

    a_r7_mret_without_u: assert property (@(posedge clk) disable iff (!rst_n)
        (mret && !trap && !u_ok) |=> (mode_q == MODE_M));

endmodule

// File: rtl/priv_status_regs.sv
module priv_status_regs
    import priv_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          AW         = 12,
    parameter logic [11:0] MSTAT_ADDR = 12'h300,
    parameter logic [11:0] SSTAT_ADDR = 12'h100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            u_ok,
    input  logic            s_ok,
    input  logic            trap,
    input  logic            mret,
    input  logic            sret,
    input  pmode_e          mode,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [AW-1:0]   addr,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] rdata,
    output logic [1:0]      mpp,
    output logic            spp
);
    localparam logic [XLEN-1:0] S_MASK = XLEN'((1 << B_SIE) | (1 << B_SPIE) | (1 << B_SPP));

    logic            mie, sie, mpie, spie;
    logic [XLEN-1:0] word;
    logic            hit_m, hit_s;
    logic            unused_wbits;

    assign unused_wbits = ^wdata;
    assign hit_m = (addr == AW'(MSTAT_ADDR));
    assign hit_s = (addr == AW'(SSTAT_ADDR));

    always_comb begin
        word              = '0;
        word[B_SIE]       = sie;
        word[B_MIE]       = mie;
        word[B_SPIE]      = spie;
        word[B_MPIE]      = mpie;
        word[B_SPP]       = spp;
        word[B_MPP_HI:B_MPP_LO] = mpp;
    end

    always_comb begin
        rdata = '0;
        if (rd_en && hit_m)      rdata = word;
        else if (rd_en && hit_s) rdata = word & S_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mie  <= 1'b0;
            sie  <= 1'b0;
            mpie <= 1'b0;
            spie <= 1'b0;
            spp  <= 1'b0;
            mpp  <= MODE_M;
        end else if (trap) begin
            mpie <= mie;
            mie  <= 1'b0;
            mpp  <= mode;
        end else if (mret) begin
            mie  <= mpie;
            mpie <= 1'b1;
            mpp  <= u_ok ? MODE_U : MODE_M;
        end else if (sret) begin
            sie  <= spie;
            spie <= 1'b1;
            spp  <= 1'b0;
        end else if (wr_en && hit_m) begin
            mie  <= wdata[B_MIE];
            sie  <= wdata[B_SIE];
            mpie <= wdata[B_MPIE];
            spie <= wdata[B_SPIE];
            spp  <= wdata[B_SPP];
            mpp  <= legalize_mode(wdata[B_MPP_HI:B_MPP_LO], u_ok, s_ok);
        end else if (wr_en && hit_s) begin
            sie  <= wdata[B_SIE];
            spie <= wdata[B_SPIE];
            spp  <= wdata[B_SPP];
        end
    end

    a_r6_alias_keeps_m_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit_s && !trap && !mret && !sret) |=> ($stable(mie) && $stable(mpie) && $stable(mpp)));

    a_r5_quiet_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !trap && !mret && !sret) |=> $stable(word));

    a_r7_mret_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (mret && !trap) |=> (mie == $past(mpie) && mpie));

    a_r8_sret_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (sret && !trap && !mret) |=> (sie == $past(spie) && spie && !spp));

    a_r2_mpp_never_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        mpp != MODE_RSV);

endmodule

// File: rtl/priv_status_unit.sv
module priv_status_unit
    import priv_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int AW   = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_umode,
    input  logic            en_smode,
    input  logic            csr_req,
    input  logic            csr_we,
    input  logic [AW-1:0]   csr_addr,
    input  logic [XLEN-1:0] csr_wdata,
    output logic [XLEN-1:0] csr_rdata,
    output logic            csr_illegal,
    input  logic            trap_take,
    input  logic            mret_take,
    input  logic            sret_take,
    output logic [1:0]      cur_mode
);
    pmode_e     mode_q;
    logic       wr_ok, rd_ok;
    logic [1:0] mpp;
    logic       spp;

    priv_csr_gate #(.AW(AW)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (csr_req),
        .we      (csr_we),
        .addr    (csr_addr),
        .mode    (mode_q),
        .illegal (csr_illegal),
        .wr_ok   (wr_ok),
        .rd_ok   (rd_ok)
    );

    priv_mode_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .u_ok   (en_umode),
        .s_ok   (en_smode),
        .trap   (trap_take),
        .mret   (mret_take),
        .sret   (sret_take),
        .mpp    (mpp),
        .spp    (spp),
        .mode_q (mode_q)
    );

    priv_status_regs #(.XLEN(XLEN), .AW(AW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .u_ok  (en_umode),
        .s_ok  (en_smode),
        .trap  (trap_take),
        .mret  (mret_take),
        .sret  (sret_take),
        .mode  (mode_q),
        .wr_en (wr_ok),
        .rd_en (rd_ok),
        .addr  (csr_addr),
        .wdata (csr_wdata),
        .rdata (csr_rdata),
        .mpp   (mpp),
        .spp   (spp)
    );

    assign cur_mode = mode_q;

    a_r5_illegal_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> (csr_rdata == '0));

endmodule

// File: tb/priv_status_unit_bench.sv
`timescale 1ns/1ps
module priv_status_unit_bench;
    localparam int XLEN = 32;
    localparam logic [11:0] AM = 12'h300;
    localparam logic [11:0] AS = 12'h100;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            en_umode = 1'b1, en_smode = 1'b1;
    logic            csr_req = 1'b0, csr_we = 1'b0;
    logic [11:0]     csr_addr = '0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [XLEN-1:0] csr_rdata;
    logic            csr_illegal;
    logic            trap_take = 1'b0, mret_take = 1'b0, sret_take = 1'b0;
    logic [1:0]      cur_mode;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    priv_status_unit u_priv_status_unit (
        .clk(clk), .rst_n(rst_n), .en_umode(en_umode), .en_smode(en_smode),
        .csr_req(csr_req), .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
        .trap_take(trap_take), .mret_take(mret_take), .sret_take(sret_take),
        .cur_mode(cur_mode)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] lg(input logic [1:0] r, input logic u, input logic s);
        if (!u) return 2'b11;
        if (r == 2'b10 || (r == 2'b01 && !s)) return 2'b00;
        return r;
    endfunction

    function automatic logic [31:0] mk(input logic mie, input logic sie, input logic mpie,
                                       input logic spie, input logic spp, input logic [1:0] mpp);
        return (32'(mie) << 3) | (32'(sie) << 1) | (32'(mpie) << 7) |
               (32'(spie) << 5) | (32'(spp) << 8) | (32'(mpp) << 11);
    endfunction

    task automatic csr_write(input logic [11:0] a, input logic [31:0] d, output logic ill);
        @(negedge clk);
        csr_req = 1'b1; csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        #1 ill = csr_illegal;
        @(negedge clk);
        csr_req = 1'b0; csr_we = 1'b0;
    endtask

    task automatic csr_read(input logic [11:0] a, output logic [31:0] d, output logic ill);
        @(negedge clk);
        csr_req = 1'b1; csr_we = 1'b0; csr_addr = a;
        #1 d = csr_rdata; ill = csr_illegal;
        csr_req = 1'b0;
    endtask

    task automatic strobe(input logic t, input logic m, input logic s);
        @(negedge clk);
        trap_take = t; mret_take = m; sret_take = s;
        @(negedge clk);
        trap_take = 1'b0; mret_take = 1'b0; sret_take = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<=150000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        logic [31:0] rd;
        logic        ill;
        logic [1:0]  lm, ls;
        for (int cu = 0; cu < 2; cu++) begin
            for (int cs = 0; cs < 2; cs++) begin
                en_umode = cu[0];
                en_smode = cs[0];
                do_reset();
                // R1 reset state
                #1 check("R1 mode", 32'(cur_mode), 32'h3);
                csr_read(AM, rd, ill);
                check("R1 mstatus", rd, 32'h0000_1800);
                check("R1 legal", 32'(ill), 32'h0);

                for (int r = 0; r < 4; r++) begin
                    lm = lg(2'(r), cu[0], cs[0]);
                    csr_write(AM, mk(0, 0, 1, 0, 0, 2'(r)), ill);
                    check("R2 write ok", 32'(ill), 32'h0);
                    csr_read(AM, rd, ill);
                    check("R2 mpp legalized", rd, mk(0, 0, 1, 0, 0, lm));
                    strobe(1'b0, 1'b1, 1'b0);
                    check("R7 R2 mret mode", 32'(cur_mode), 32'(lm));
                    if (lm == 2'b11) begin
                        csr_read(AM, rd, ill);
                        check("R7 mret fields", rd, mk(1, 0, 1, 0, 0, cu[0] ? 2'b00 : 2'b11));
                    end
                    for (int hi = 0; hi < 16; hi++) begin
                        for (int w = 0; w < 2; w++) begin
                            logic [1:0] need;
                            logic       exp_ill;
                            logic [3:0] h4;
                            h4 = 4'(hi);
                            need = (h4[1:0] == 2'b10) ? 2'b01 : h4[1:0];
                            exp_ill = (lm < need) || (w == 1 && h4[3:2] == 2'b11);
                            @(negedge clk);
                            csr_req = 1'b1; csr_we = w[0]; csr_addr = {h4, 8'h42}; csr_wdata = '0;
                            #1;
                            if (w == 1 && h4[3:2] == 2'b11)
                                check("R4 ro write", 32'(csr_illegal), 32'(exp_ill));
                            else
                                check("R3 level", 32'(csr_illegal), 32'(exp_ill));
                            csr_req = 1'b0; csr_we = 1'b0;
                        end
                    end
                    strobe(1'b1, 1'b0, 1'b0);
                    check("R9 trap mode", 32'(cur_mode), 32'h3);
                    csr_read(AM, rd, ill);
                    check("R9 trap fields", rd, mk(0, 0, 1, 0, 0, lm));
                end

                // R6 supervisor view
                csr_write(AM, 32'h0000_19AA, ill);
                csr_read(AM, rd, ill);
                check("R6 full write", rd, 32'h0000_19AA);
                csr_write(AS, 32'h0, ill);
                csr_read(AM, rd, ill);
                check("R6 s-clear keeps m bits", rd, 32'h0000_1888);
                csr_read(AS, rd, ill);
                check("R6 s view zero", rd, 32'h0);
                csr_write(AS, 32'hFFFF_FFFF, ill);
                csr_read(AS, rd, ill);
                check("R6 s view masked", rd, 32'h0000_0122);
                csr_read(AM, rd, ill);
                check("R6 s-set keeps m bits", rd, 32'h0000_19AA);

                // R8 supervisor return, then accesses from the new mode
                csr_write(AM, mk(0, 0, 0, 1, 1, 2'b11), ill);
                strobe(1'b0, 1'b0, 1'b1);
                ls = lg(2'b01, cu[0], cs[0]);
                check("R8 sret mode", 32'(cur_mode), 32'(ls));
                csr_read(AS, rd, ill);
                check("R3 s view access", 32'(ill), 32'(ls == 2'b00));
                check("R8 R5 s view after sret", rd, (ls == 2'b00) ? 32'h0 : 32'h0000_0022);
                csr_read(AM, rd, ill);
                check("R5 m read from lower", rd, (ls == 2'b11) ? mk(0, 1, 0, 1, 0, 2'b11) : 32'h0);
                csr_write(AM, 32'h0, ill);
                check("R3 m write level", 32'(ill), 32'(ls != 2'b11));
                strobe(1'b1, 1'b0, 1'b0);
                csr_read(AM, rd, ill);
                check("R5 refused write no effect", rd,
                      (ls == 2'b11) ? 32'h0000_1800 : mk(0, 1, 0, 1, 0, ls));

                // R10 simultaneous events
                csr_write(AM, mk(0, 0, 1, 0, 0, 2'b00), ill);
                @(negedge clk);
                trap_take = 1'b1; mret_take = 1'b1; sret_take = 1'b1;
                csr_req = 1'b1; csr_we = 1'b1; csr_addr = AM; csr_wdata = 32'h0000_19AA;
                @(negedge clk);
                trap_take = 1'b0; mret_take = 1'b0; sret_take = 1'b0;
                csr_req = 1'b0; csr_we = 1'b0;
                check("R10 trap wins mode", 32'(cur_mode), 32'h3);
                csr_read(AM, rd, ill);
                check("R10 trap wins fields", rd, mk(0, 0, 0, 0, 0, 2'b11));
                @(negedge clk);
                mret_take = 1'b1; sret_take = 1'b1;
                @(negedge clk);
                mret_take = 1'b0; sret_take = 1'b0;
                check("R10 mret over sret", 32'(cur_mode), 32'(lg(2'b11, cu[0], cs[0])));
                strobe(1'b1, 1'b0, 1'b0);
                csr_read(AM, rd, ill);
                check("R10 sret ignored", rd, mk(0, 0, 0, 0, 0, 2'b11));
            end
        end
        finish_run();
    end
endmodule